// File: doc/BRIEF.md
# PCM Serial Voice Port

This block moves voice samples between a parallel sample interface and a synchronous serial link. The link has two serial data inputs and two serial data outputs that share one bit clock and one frame sync. Each frame carries one word per lane. A word is either an 8-bit companded byte, which passes through untouched, or a 16-bit two's-complement sample. The two outputs are driven only inside the data slot and are released, as high impedance, everywhere else.

As clock master, the port divides its master clock down to a bit clock and an 8 kHz frame sync and drives both. As clock slave, it takes both from outside and resynchronises them into the master-clock domain. The start of each word follows one of two alignments. In the normal alignment the first bit is in the period where sync first goes high. In the short-frame alignment the first bit follows a one-bit-long sync pulse. A watchdog on the sync line raises a power-down request when the sync stops toggling.

Top module: `pcm_voice_port`

## Requirements
- R1: With `clk_sel`=0 the bit clock `bclk_o` has a period of `DIV_LIN` master clocks when `fmt_sel`=0 (16-bit words) and `DIV_MU` master clocks when `fmt_sel`=1 (8-bit words).
- R2: As master, a frame lasts as many bit periods as the word has bits. With `sync_sel`=0 `fsync_o` is high for the first half of the frame. With `sync_sel`=1 it is high for exactly one bit period, the last one of the frame.
- R3: With `clk_sel`=1 the port frames on `bclk_i`/`fsync_i`, holds `clk_drive` low and leaves `bclk_o` at 0. Slave bit clocks may be slower or faster than the master ones, and frames may be longer than one word.
- R4: Words leave most significant bit first, one bit per bit-clock rise. In 8-bit mode `tx_a`/`tx_b` bits 7..0 are sent; in 16-bit mode bits 15..0 are sent.
- R5: With `sync_sel`=0 the first bit is launched at the bit-clock rise where the sampled sync changes from low to high.
- R6: With `sync_sel`=1 the first bit is launched at the bit-clock rise that follows a rise at which sync was high after being low.
- R7: Each serial input bit is sampled at the bit-clock rise that ends its period. When a word is complete, `rx_a`/`rx_b` present it, right-aligned and zero-extended in 8-bit mode, with a one-cycle `rx_valid` pulse.
- R8: `sdo_en` is high only during the word's bit periods. It is low during reset, before the first frame, and after the last bit of a word until the next start.
- R9: `pd_req` rises once the selected frame sync shows no edge for `SYNC_TIMEOUT` master clocks. It stays high until the next edge, which clears it.
- R10: The transmit words are captured at the start of the slot. A change of `tx_a` during the slot does not alter the word being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset; mode inputs change only under reset |
| clk_sel | input | 1 | 0: generate clocks (master), 1: use external clocks (slave) |
| fmt_sel | input | 1 | 1: 8-bit companded words, 0: 16-bit linear words |
| sync_sel | input | 1 | 0: normal alignment, 1: short-frame alignment |
| bclk_i | input | 1 | External bit clock (slave) |
| fsync_i | input | 1 | External frame sync (slave) |
| bclk_o | output | 1 | Generated bit clock (master) |
| fsync_o | output | 1 | Generated frame sync (master) |
| clk_drive | output | 1 | Output enable for the bit clock and frame sync pins |
| sdi_a | input | 1 | Serial data in, lane A |
| sdi_b | input | 1 | Serial data in, lane B |
| sdo_a | output | 1 | Serial data out, lane A |
| sdo_b | output | 1 | Serial data out, lane B |
| sdo_en | output | 1 | Output enable of both serial data outputs (low = high impedance) |
| tx_a | input | 16 | Word to send on lane A |
| tx_b | input | 16 | Word to send on lane B |
| rx_a | output | 16 | Last word received on lane A |
| rx_b | output | 16 | Last word received on lane B |
| rx_valid | output | 1 | One-cycle pulse when `rx_a`/`rx_b` are updated |
| pd_req | output | 1 | Power-down request on a stuck frame sync |

## Verification
The bench builds the port with `DIV_LIN`=8, `DIV_MU`=16 and `SYNC_TIMEOUT`=200. A master frame therefore lasts 128 master clocks in either word format, and a stuck sync trips the watchdog within a few hundred cycles. This puts both word formats, both alignments and the power-down request within reach of a short run. In slave mode the bench runs two bit-clock rates and a frame longer than one word, so the released outputs after the slot can be observed. The serial outputs are looped back to the inputs, so each random word is checked both at the pins and at the receive port.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

  // Number of bits in one word for the selected format.
  function automatic logic [4:0] word_bits(input logic byte_mode);
    return byte_mode ? 5'd8 : 5'd16;
  endfunction

  // Place the word to be sent at the top of the shifter (MSB out first).
  function automatic logic [15:0] tx_align(input logic [15:0] w, input logic byte_mode);
    return byte_mode ? {w[7:0], 8'h00} : w;
  endfunction

  // Right-align a received word; bytes are zero-extended.
  function automatic logic [15:0] rx_trim(input logic [15:0] s, input logic byte_mode);
    return byte_mode ? {8'h00, s[7:0]} : s;
  endfunction

endpackage

// File: rtl/pcm_clkgen.sv
module pcm_clkgen #(
  parameter int DIV_LIN = 150,
  parameter int DIV_MU  = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic byte_mode,
  input  logic short_sync,
  output logic bclk_q,
  output logic fsync_q,
  output logic rise,
  output logic fsync_next
);
  import pcm_port_pkg::*;

  localparam int DIV_MAX = (DIV_MU > DIV_LIN) ? DIV_MU : DIV_LIN;
  localparam int CW      = $clog2(DIV_MAX + 1);

  logic [CW-1:0] divc, div_n, half;
  logic [3:0]    fcnt, fcnt_next;
  logic [4:0]    wbits;

  always_comb begin
    div_n      = byte_mode ? CW'(DIV_MU) : CW'(DIV_LIN);
    half       = div_n >> 1;
    wbits      = word_bits(byte_mode);
    rise       = enable && (divc == div_n - 1'b1);
    fcnt_next  = ({1'b0, fcnt} >= wbits - 5'd1) ? 4'd0 : fcnt + 4'd1;
    fsync_next = short_sync ? ({1'b0, fcnt_next} == wbits - 5'd1)
                            : ({1'b0, fcnt_next} < (wbits >> 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divc    <= '0;
      bclk_q  <= 1'b0;
      fcnt    <= 4'd15;
      fsync_q <= 1'b0;
    end else if (!enable) begin
      divc    <= '0;
      bclk_q  <= 1'b0;
      fcnt    <= 4'd15;
      fsync_q <= 1'b0;
    end else begin
      divc <= rise ? '0 : divc + 1'b1;
      if (rise) begin
        bclk_q  <= 1'b1;
        fcnt    <= fcnt_next;
        fsync_q <= fsync_next;
      end else if (divc == half - 1'b1) begin
        bclk_q  <= 1'b0;
      end
    end
  end

  // R1: every divider wrap is a bit-clock rising edge on the pin
  assert_bclk_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> bclk_q);

endmodule

// File: rtl/pcm_edge_sync.sv
module pcm_edge_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-2:0] rest,
  output logic         rise0
);
  logic [N-1:0] chain [STAGES];
  logic         last0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
      last0 <= 1'b0;
    end else begin
      chain[0] <= din;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      last0 <= chain[STAGES-1][0];
    end
  end

  assign rest  = chain[STAGES-1][N-1:1];
  assign rise0 = chain[STAGES-1][0] & ~last0;

endmodule

// File: rtl/pcm_sync_watch.sv
module pcm_sync_watch #(
  parameter int TIMEOUT = 4800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_lvl,
  output logic sync_edge,
  output logic pd_req
);
  localparam int CW = $clog2(TIMEOUT + 1);

  logic          prev;
  logic [CW-1:0] cnt;

  assign sync_edge = sync_lvl ^ prev;
  assign pd_req    = (cnt == CW'(TIMEOUT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= 1'b0;
      cnt  <= '0;
    end else begin
      prev <= sync_lvl;
      if (sync_edge)    cnt <= '0;
      else if (!pd_req) cnt <= cnt + 1'b1;
    end
  end

  // R9: an edge always withdraws the request
  assert_pd_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sync_edge |=> !pd_req);
  // R9: the request is held while the sync stays still
  assert_pd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_req && !sync_edge) |=> pd_req);

endmodule

// File: rtl/pcm_lane.sv
module pcm_lane (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic        adv,
  input  logic        cap,
  input  logic        cap_last,
  input  logic        byte_mode,
  input  logic [15:0] tx_word,
  input  logic        sdi,
  output logic        sdo,
  output logic [15:0] rx_word,
  output logic        rx_stb
);
  import pcm_port_pkg::*;

  logic [15:0] txsh, rxsh;

  assign sdo = txsh[15];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txsh    <= '0;
      rxsh    <= '0;
      rx_word <= '0;
      rx_stb  <= 1'b0;
    end else begin
      if (load)     txsh <= tx_align(tx_word, byte_mode);
      else if (adv) txsh <= {txsh[14:0], 1'b0};
      if (cap)      rxsh <= {rxsh[14:0], sdi};
      rx_stb <= cap_last;
      if (cap_last) rx_word <= rx_trim({rxsh[14:0], sdi}, byte_mode);
    end
  end

  // R4: the first bit on the pin is the word's top bit
  assert_load_msb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (sdo == $past(byte_mode ? tx_word[7] : tx_word[15])));

endmodule

// File: rtl/pcm_voice_port.sv
module pcm_voice_port #(
  parameter int DIV_LIN      = 150,
  parameter int DIV_MU       = 300,
  parameter int SYNC_TIMEOUT = 4800,
  parameter int SYNC_STAGES  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clk_sel,
  input  logic        fmt_sel,
  input  logic        sync_sel,
  input  logic        bclk_i,
  input  logic        fsync_i,
  output logic        bclk_o,
  output logic        fsync_o,
  output logic        clk_drive,
  input  logic        sdi_a,
  input  logic        sdi_b,
  output logic        sdo_a,
  output logic        sdo_b,
  output logic        sdo_en,
  input  logic [15:0] tx_a,
  input  logic [15:0] tx_b,
  output logic [15:0] rx_a,
  output logic [15:0] rx_b,
  output logic        rx_valid,
  output logic        pd_req
);
  import pcm_port_pkg::*;

  localparam int LANES = 2;
  localparam int SN    = 2 + LANES;

  logic             master, m_rise, m_fsync_next, m_fsync_q;
  logic             s_rise, bit_rise, sync_at, sync_lvl, sync_edge;
  logic [SN-2:0]    s_rest;
  logic [LANES-1:0] din_v, sdo_v, stb_v;
  logic [15:0]      tx_v [LANES];
  logic [15:0]      rx_v [LANES];
  logic [1:0]       hist;
  logic             start, in_slot, cap, cap_last, adv;
  logic [3:0]       bitidx;
  logic [4:0]       wbits;

  assign master = !clk_sel;

  pcm_clkgen #(.DIV_LIN(DIV_LIN), .DIV_MU(DIV_MU)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .enable(master), .byte_mode(fmt_sel),
    .short_sync(sync_sel), .bclk_q(bclk_o), .fsync_q(m_fsync_q),
    .rise(m_rise), .fsync_next(m_fsync_next)
  );

  pcm_edge_sync #(.N(SN), .STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .din({sdi_b, sdi_a, fsync_i, bclk_i}),
    .rest(s_rest), .rise0(s_rise)
  );

  pcm_sync_watch #(.TIMEOUT(SYNC_TIMEOUT)) u_watch (
    .clk(clk), .rst_n(rst_n), .sync_lvl(sync_lvl),
    .sync_edge(sync_edge), .pd_req(pd_req)
  );

  assign fsync_o   = m_fsync_q;
  assign clk_drive = master;
  assign bit_rise  = master ? m_rise : s_rise;
  assign sync_at   = master ? m_fsync_next : s_rest[0];
  assign sync_lvl  = master ? m_fsync_q : s_rest[0];
  assign din_v     = master ? {sdi_b, sdi_a} : s_rest[SN-2:1];
  assign wbits     = word_bits(fmt_sel);

  // Word start: normal = sync seen rising at this rise;
  // short = the previous rise saw the one-bit pulse.
  assign start    = bit_rise && (sync_sel ? (hist[0] && !hist[1]) : (sync_at && !hist[0]));
  assign cap      = bit_rise && in_slot;
  assign cap_last = cap && ({1'b0, bitidx} == wbits - 5'd1);
  assign adv      = cap && !start && !cap_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist    <= 2'b00;
      in_slot <= 1'b0;
      bitidx  <= 4'd0;
    end else begin
      if (bit_rise) hist <= {hist[0], sync_at};
      if (start) begin
        in_slot <= 1'b1;
        bitidx  <= 4'd0;
      end else if (cap_last) begin
        in_slot <= 1'b0;
      end else if (cap) begin
        bitidx  <= bitidx + 4'd1;
      end
    end
  end

  assign tx_v[0] = tx_a;
  assign tx_v[1] = tx_b;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      pcm_lane u_lane (
        .clk(clk), .rst_n(rst_n), .load(start), .adv(adv), .cap(cap),
        .cap_last(cap_last), .byte_mode(fmt_sel), .tx_word(tx_v[g]),
        .sdi(din_v[g]), .sdo(sdo_v[g]), .rx_word(rx_v[g]), .rx_stb(stb_v[g])
      );
    end
  endgenerate

  assign sdo_a    = sdo_v[0];
  assign sdo_b    = sdo_v[1];
  assign rx_a     = rx_v[0];
  assign rx_b     = rx_v[1];
  assign rx_valid = &stb_v;
  assign sdo_en   = in_slot;

  // R5: a detected start drives the slot from the next cycle
  assert_start_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> sdo_en);
  // R8: outputs are released after the last bit unless a new word starts
  assert_slot_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_last && !start) |=> !sdo_en);
  // R7: a received word is announced for a single cycle
  assert_rx_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

endmodule

// File: tb/tb_pcm_voice_port.sv
`timescale 1ns/1ps
module tb_pcm_voice_port;
  localparam int DLIN = 8, DMU = 16, TMO = 200;

  logic clk = 0, rst_n = 0, clk_sel = 0, fmt_sel = 0, sync_sel = 0;
  logic bclk_i = 0, fsync_i = 0;
  logic [15:0] tx_a = 0, tx_b = 0;
  logic bclk_o, fsync_o, clk_drive, sdo_a, sdo_b, sdo_en, rx_valid, pd_req;
  logic sdi_a, sdi_b;
  logic [15:0] rx_a, rx_b;

  int checks = 0, fails = 0;
  bit slv_on = 0, slv_stuck = 0;
  int slv_half = 8, slv_bits = 20;
  int rx_seen = 0;
  logic [15:0] got_a = 0, got_b = 0;

  always #2.5 clk = ~clk;

  pcm_voice_port #(.DIV_LIN(DLIN), .DIV_MU(DMU), .SYNC_TIMEOUT(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .fmt_sel(fmt_sel), .sync_sel(sync_sel),
    .bclk_i(bclk_i), .fsync_i(fsync_i), .bclk_o(bclk_o), .fsync_o(fsync_o),
    .clk_drive(clk_drive), .sdi_a(sdi_a), .sdi_b(sdi_b), .sdo_a(sdo_a), .sdo_b(sdo_b),
    .sdo_en(sdo_en), .tx_a(tx_a), .tx_b(tx_b), .rx_a(rx_a), .rx_b(rx_b),
    .rx_valid(rx_valid), .pd_req(pd_req)
  );

  // serial loopback, released pins read as 0
  assign sdi_a = sdo_en ? sdo_a : 1'b0;
  assign sdi_b = sdo_en ? sdo_b : 1'b0;
  wire bclk_pin  = clk_sel ? bclk_i : bclk_o;
  wire fsync_pin = clk_sel ? fsync_i : fsync_o;

  // external clock source for slave runs; sync set up before each rise
  initial begin : slave_gen
    int k;
    k = 0;
    forever begin
      if (!slv_on) begin
        k = 0; bclk_i = 0; @(negedge clk);
      end else begin
        bclk_i = 0;
        if (!slv_stuck) fsync_i = sync_sel ? (k == slv_bits - 1) : (k < slv_bits / 2);
        repeat (slv_half) @(negedge clk);
        bclk_i = 1;
        repeat (slv_half) @(negedge clk);
        k = (k + 1) % slv_bits;
      end
    end
  end

  always @(negedge clk) if (rx_valid) begin
    got_a = rx_a; got_b = rx_b; rx_seen++;
  end

  function automatic logic [15:0] exp_word(logic [15:0] v, int w);
    return (w == 8) ? {8'h00, v[7:0]} : v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic cs, input logic fm, input logic ss);
    @(negedge clk);
    rst_n = 0; slv_on = 0; slv_stuck = 0;
    clk_sel = cs; fmt_sel = fm; sync_sel = ss;
    repeat (4) @(negedge clk);
    chk(sdo_en == 0, "R8 released in reset", sdo_en, 0);
    chk(rx_valid == 0 && pd_req == 0 && bclk_o == 0, "R9 quiet reset state",
        {rx_valid, pd_req, bclk_o}, 0);
    rst_n = 1;
    slv_on = cs;
    chk(clk_drive == !cs, "R3 clock pin drive", clk_drive, !cs);
  endtask

  task automatic grab(output logic [15:0] wa, output logic [15:0] wb,
                      input int w, input int dly, input bit flip);
    logic h0, h1, s;
    bit found;
    h0 = 1; h1 = 1; found = 0; wa = 0; wb = 0;
    for (int n = 0; n < 80 && !found; n++) begin
      @(posedge bclk_pin); #1;
      s = fsync_pin;
      found = sync_sel ? (h0 && !h1) : (s && !h0);
      h1 = h0; h0 = s;
    end
    if (!found) chk(0, "R5 frame start seen", 0, 1);
    for (int i = 0; i < w; i++) begin
      if (i > 0) @(posedge bclk_pin);
      repeat (dly) @(negedge clk);
      chk(sdo_en === 1'b1, "R8 driven in slot", sdo_en, 1);
      wa = {wa[14:0], sdo_a};
      wb = {wb[14:0], sdo_b};
      if (flip && i == 3) tx_a = ~tx_a;
    end
  endtask

  task automatic frame_test(input int w, input int dly, input bit flip, input bit hiz, input string tag);
    logic [15:0] ta, tb, pa, pb;
    int n0, lim;
    @(negedge clk);
    ta = 16'($urandom); tb = 16'($urandom);
    tx_a = ta; tx_b = tb;
    grab(pa, pb, w, dly, flip);
    n0 = rx_seen;
    chk(pa == exp_word(ta, w), {tag, " R4 lane A pin word", flip ? " R10" : ""}, pa, exp_word(ta, w));
    chk(pb == exp_word(tb, w), {tag, " R4 lane B pin word"}, pb, exp_word(tb, w));
    if (hiz) begin
      @(posedge bclk_pin);
      repeat (dly) @(negedge clk);
      chk(sdo_en == 0, "R8 released after word", sdo_en, 0);
    end
    lim = 0;
    while (rx_seen == n0 && lim < 3000) begin @(negedge clk); lim++; end
    chk(got_a == exp_word(ta, w), "R7 lane A received", got_a, exp_word(ta, w));
    chk(got_b == exp_word(tb, w), "R7 lane B received", got_b, exp_word(tb, w));
  endtask

  task automatic measure(input int w, input int div, input bit shrt);
    realtime t0, t1, t2;
    int per, hi, fp;
    @(posedge bclk_o); t0 = $realtime;
    @(posedge bclk_o); t1 = $realtime;
    per = int'((t1 - t0) / 5.0);
    chk(per == div, "R1 bit clock period", per, div);
    @(posedge fsync_o); t0 = $realtime;
    @(negedge fsync_o); t1 = $realtime;
    @(posedge fsync_o); t2 = $realtime;
    hi = int'((t1 - t0) / 5.0);
    fp = int'((t2 - t0) / 5.0);
    chk(hi == (shrt ? div : (w / 2) * div), "R2 sync high time", hi, shrt ? div : (w / 2) * div);
    chk(fp == w * div, "R2 frame period", fp, w * div);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R5 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2718));
    // master, 16-bit, normal alignment
    do_reset(0, 0, 0);
    chk(sdo_en == 0, "R8 idle before first frame", sdo_en, 0);
    measure(16, DLIN, 0);
    for (int i = 0; i < 4; i++) frame_test(16, 2, i == 1, 0, "R5");
    chk(pd_req == 0, "R9 no request while sync runs", pd_req, 0);
    // master, 16-bit, short frame
    do_reset(0, 0, 1);
    measure(16, DLIN, 1);
    for (int i = 0; i < 3; i++) frame_test(16, 2, 0, 0, "R6");
    // master, 8-bit, normal
    do_reset(0, 1, 0);
    measure(8, DMU, 0);
    for (int i = 0; i < 3; i++) frame_test(8, 2, i == 2, 0, "R5");
    // master, 8-bit, short frame
    do_reset(0, 1, 1);
    measure(8, DMU, 1);
    for (int i = 0; i < 3; i++) frame_test(8, 2, 0, 0, "R6");
    // slave, 16-bit, normal, 20-bit frames
    slv_half = 8; slv_bits = 20;
    do_reset(1, 0, 0);
    for (int i = 0; i < 3; i++) frame_test(16, 5, 0, 1, "R3 R5");
    chk(bclk_o == 0 && clk_drive == 0, "R3 master clock idle", {bclk_o, clk_drive}, 0);
    @(negedge clk); slv_stuck = 1;
    repeat (20) @(negedge clk);
    chk(pd_req == 0, "R9 no request before timeout", pd_req, 0);
    repeat (TMO + 40) @(negedge clk);
    chk(pd_req == 1, "R9 request on stuck sync", pd_req, 1);
    slv_stuck = 0;
    repeat (400) @(negedge clk);
    chk(pd_req == 0, "R9 request cleared by edge", pd_req, 0);
    // slave, 8-bit, short frame, other rate
    slv_half = 12; slv_bits = 16;
    do_reset(1, 1, 1);
    for (int i = 0; i < 3; i++) frame_test(8, 5, 0, 0, "R3 R6");
    finish_run();
  end

endmodule